// File: doc/BRIEF.md
# Pipelined fixed-point sine and cosine generator

This block turns a binary angle into its sine and cosine in signed fixed point. A CORDIC rotation pipeline is fully unrolled, with one register stage for each micro-rotation. It therefore takes a fresh angle on every clock and, after a fixed delay, returns one sine/cosine pair per clock. A stream of angles with gaps gives a stream of results with the same gaps.

The rotation stages only work over a quarter turn. Before the first stage, the angle is reduced to its offset inside its quadrant. The quadrant number travels through the pipeline beside its own sample. After the last stage it decides whether the two results are swapped and which of them is negated. The CORDIC gain is cancelled by starting the vector at a reduced length on the x axis. The results therefore land on a circle of radius 32764 LSB, which is just below full scale.

Top module: `cordic_sincos`

## Requirements
- R1: While reset is held and in the first cycle after it is released, outValid is low.
- R2: outValid is high in a cycle exactly when inValid was high 16 cycles earlier, and the result in that cycle belongs to that input.
- R3: Angles presented on consecutive clocks produce results on consecutive clocks, each belonging to its own input, with no lost or repeated samples.
- R4: outSin and outCos equal 32764·sin(θ) and 32764·cos(θ) to within 6 LSB, where θ = 2π·inAngle/65536.
- R5: inAngle is an unsigned 16-bit binary angle where 65536 is one full turn. inAngle[15:14] is the quadrant, with 0 covering [0°,90°), 1 covering [90°,180°), 2 covering [180°,270°) and 3 covering [270°,360°). Angles on the quadrant boundaries 0x4000, 0x8000 and 0xC000 give (sin, cos) close to (+A, 0), (0, −A) and (−A, 0), where A = 32764.
- R6: Whenever the true sine or cosine exceeds 1000 LSB in magnitude, the output takes the sign that matches the quadrant of the input angle.
- R7: Every result has a magnitude sqrt(sin²+cos²) within 8 LSB of 32764, and neither output ever equals −32768.
- R8: A cycle with inValid low produces a cycle with outValid low 16 cycles later, and the angle value in that cycle has no effect on any result.
- R9: Angles at the very edges of the circle (0x0000, 0x0001, 0x3FFF, 0xFFFF) meet the accuracy of R4, including the sign of a near-zero component.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset of the valid path |
| inValid | input | 1 | Marks inAngle as a sample to convert |
| inAngle | input | 16 | Unsigned binary angle, 65536 per turn |
| outValid | output | 1 | Marks outSin/outCos as a result |
| outSin | output | 16 | Signed sine, Q1.15 |
| outCos | output | 16 | Signed cosine, Q1.15 |

## Verification
The hardest cases to reach are the angles where the quadrant mapping must swap the two outputs and negate one of them. This happens right at a quadrant edge, where one component is near zero and a wrong restore gives a small value of the wrong sign, or a full-scale value where none is expected. The stimulus drives each boundary code and its nearest neighbours as isolated samples. It then sweeps the whole circle on back-to-back clocks, so that a quadrant code that slips by one stage against its data is paired with the neighbouring sample in a different quadrant and is caught. A long run with random gaps follows, to show that idle cycles keep their place in the stream.

// File: rtl/cordic_pkg.sv
package cordic_pkg;

  // Angle resolution used inside the rotation stages: 2^TURN_BITS per turn.
  localparam int TURN_BITS = 20;

  // Output fix-up strobes that control hands to the datapath.
  typedef struct packed {
    logic swapXY;
    logic negSin;
    logic negCos;
  } fix_t;

  // Micro-rotation angle atan(2^-i) in units of 2^-TURN_BITS turn.
  function automatic int atanStep(input int i);
    case (i)
      0:  atanStep = 131072;
      1:  atanStep = 77376;
      2:  atanStep = 40884;
      3:  atanStep = 20753;
      4:  atanStep = 10417;
      5:  atanStep = 5213;
      6:  atanStep = 2607;
      7:  atanStep = 1304;
      8:  atanStep = 652;
      9:  atanStep = 326;
      10: atanStep = 163;
      11: atanStep = 81;
      12: atanStep = 41;
      13: atanStep = 20;
      14: atanStep = 10;
      15: atanStep = 5;
      default: atanStep = 0;
    endcase
  endfunction

endpackage

// File: rtl/cordic_ctrl.sv
module cordic_ctrl
  import cordic_pkg::*;
#(
  parameter int STAGES = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic [1:0] inQuad,
  output logic       outValid,
  output fix_t       fix
);

  logic       vPipe [STAGES];
  logic [1:0] qPipe [STAGES];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) vPipe[i] <= 1'b0;
    end else begin
      vPipe[0] <= inValid;
      for (int i = 1; i < STAGES; i++) vPipe[i] <= vPipe[i-1];
    end
  end

  always_ff @(posedge clk) begin
    qPipe[0] <= inQuad;
    for (int i = 1; i < STAGES; i++) qPipe[i] <= qPipe[i-1];
  end

  assign outValid = vPipe[STAGES-1];

  // Quadrant restore: q1 -> (cos, -sin), q2 -> (-sin, -cos), q3 -> (-cos, sin)
  always_comb begin
    fix = '0;
    case (qPipe[STAGES-1])
      2'd1:    begin fix.swapXY = 1'b1; fix.negCos = 1'b1; end
      2'd2:    begin fix.negSin = 1'b1; fix.negCos = 1'b1; end
      2'd3:    begin fix.swapXY = 1'b1; fix.negSin = 1'b1; end
      default: fix = '0;
    endcase
  end

endmodule

// File: rtl/cordic_dp.sv
module cordic_dp
  import cordic_pkg::*;
#(
  parameter int ANGLE_W = 16,
  parameter int DATA_W  = 16,
  parameter int GUARD   = 3,
  parameter int STAGES  = 16
) (
  input  logic                     clk,
  input  logic [ANGLE_W-3:0]       phi,
  input  fix_t                     fix,
  output logic signed [DATA_W-1:0] outSin,
  output logic signed [DATA_W-1:0] outCos
);

  localparam int XY_W = DATA_W + GUARD + 1;
  localparam int Z_W  = TURN_BITS;
  localparam int AMP  = 2**(DATA_W-1) - 4;
  // Start length AMP/K so the finished vector has radius AMP.
  localparam longint X_INIT_L = longint'(AMP) * longint'(2**GUARD) * 64'd607253 / 64'd1000000;
  localparam logic signed [XY_W-1:0] X_INIT = XY_W'(X_INIT_L);

  logic signed [Z_W-1:0] zFold;
  assign zFold = Z_W'(phi) <<< (TURN_BITS - ANGLE_W);

  for (genvar i = 0; i < STAGES; i++) begin : g_stg
    localparam logic signed [Z_W-1:0] STEP = Z_W'(atanStep(i));
    logic signed [XY_W-1:0] xSrc, ySrc, xq, yq;
    logic signed [Z_W-1:0]  zSrc;
    logic                   ccw;

    if (i == 0) begin : g_first
      assign xSrc = X_INIT;
      assign ySrc = '0;
      assign zSrc = zFold;
    end else begin : g_next
      assign xSrc = g_stg[i-1].xq;
      assign ySrc = g_stg[i-1].yq;
      assign zSrc = g_stg[i-1].g_z.zq;
    end

    assign ccw = ~zSrc[Z_W-1];

    always_ff @(posedge clk) begin
      if (ccw) begin
        xq <= xSrc - (ySrc >>> i);
        yq <= ySrc + (xSrc >>> i);
      end else begin
        xq <= xSrc + (ySrc >>> i);
        yq <= ySrc - (xSrc >>> i);
      end
    end

    if (i < STAGES - 1) begin : g_z
      logic signed [Z_W-1:0] zq;
      always_ff @(posedge clk) begin
        zq <= ccw ? (zSrc - STEP) : (zSrc + STEP);
      end
    end
  end

  logic signed [DATA_W-1:0] xOut, yOut, sPick, cPick;
  assign xOut  = g_stg[STAGES-1].xq[GUARD +: DATA_W];
  assign yOut  = g_stg[STAGES-1].yq[GUARD +: DATA_W];
  assign sPick = fix.swapXY ? xOut : yOut;
  assign cPick = fix.swapXY ? yOut : xOut;
  assign outSin = fix.negSin ? -sPick : sPick;
  assign outCos = fix.negCos ? -cPick : cPick;

endmodule

// File: rtl/cordic_sincos.sv
module cordic_sincos
  import cordic_pkg::*;
#(
  parameter int ANGLE_W = 16,
  parameter int DATA_W  = 16,
  parameter int GUARD   = 3,
  parameter int STAGES  = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     inValid,
  input  logic [ANGLE_W-1:0]       inAngle,
  output logic                     outValid,
  output logic signed [DATA_W-1:0] outSin,
  output logic signed [DATA_W-1:0] outCos
);

  fix_t fix;

  cordic_ctrl #(.STAGES(STAGES)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inQuad   (inAngle[ANGLE_W-1 -: 2]),
    .outValid (outValid),
    .fix      (fix)
  );

  cordic_dp #(
    .ANGLE_W (ANGLE_W),
    .DATA_W  (DATA_W),
    .GUARD   (GUARD),
    .STAGES  (STAGES)
  ) u_dp (
    .clk    (clk),
    .phi    (inAngle[ANGLE_W-3:0]),
    .fix    (fix),
    .outSin (outSin),
    .outCos (outCos)
  );

endmodule

// File: rtl/cordic_sincos_chk.sv
module cordic_sincos_chk #(
  parameter int ANGLE_W = 16,
  parameter int DATA_W  = 16,
  parameter int STAGES  = 16
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     inValid,
  input logic [ANGLE_W-1:0]       inAngle,
  input logic                     outValid,
  input logic signed [DATA_W-1:0] outSin,
  input logic signed [DATA_W-1:0] outCos
);

  localparam int AMP    = 2**(DATA_W-1) - 4;
  localparam int QTR    = 2**(ANGLE_W-2);
  localparam int MARGIN = QTR / 32;

  logic               hVal [STAGES];
  logic [ANGLE_W-1:0] hAng [STAGES];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) hVal[i] <= 1'b0;
    end else begin
      hVal[0] <= inValid;
      for (int i = 1; i < STAGES; i++) hVal[i] <= hVal[i-1];
    end
  end

  always_ff @(posedge clk) begin
    hAng[0] <= inAngle;
    for (int i = 1; i < STAGES; i++) hAng[i] <= hAng[i-1];
  end

  logic [1:0]          oldQuad;
  logic [ANGLE_W-3:0]  oldPhi;
  logic                inMargin, signOk;
  logic [DATA_W:0]     absS, absC, absSum;

  always_comb begin
    oldQuad  = hAng[STAGES-1][ANGLE_W-1 -: 2];
    oldPhi   = hAng[STAGES-1][ANGLE_W-3:0];
    inMargin = (int'(oldPhi) >= MARGIN) && (int'(oldPhi) <= QTR - MARGIN);
    case (oldQuad)
      2'd0:    signOk = (outSin > 0) && (outCos > 0);
      2'd1:    signOk = (outSin > 0) && (outCos < 0);
      2'd2:    signOk = (outSin < 0) && (outCos < 0);
      default: signOk = (outSin < 0) && (outCos > 0);
    endcase
    absS   = outSin[DATA_W-1] ? (DATA_W+1)'(-outSin) : (DATA_W+1)'(outSin);
    absC   = outCos[DATA_W-1] ? (DATA_W+1)'(-outCos) : (DATA_W+1)'(outCos);
    absSum = absS + absC;
  end

  // R2: output strobe follows the input strobe by the pipeline depth
  a_r2_valid_latency: assert property (@(posedge clk) disable iff (!rstN)
    outValid == hVal[STAGES-1]);

  // R6: signs agree with the quadrant of the matching input
  a_r6_quadrant_sign: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && inMargin) |-> signOk);

  // R7: result sits near the circle of radius AMP (|s|+|c| lies in [r, r*sqrt2])
  a_r7_unit_magnitude: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> ((int'(absSum) >= AMP - 8) && (int'(absSum) <= (AMP * 1415) / 1000 + 8)));

  // R7: no wrap to the most negative code
  a_r7_no_negfull: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> ((outSin != {1'b1, {(DATA_W-1){1'b0}}}) && (outCos != {1'b1, {(DATA_W-1){1'b0}}})));

endmodule

bind cordic_sincos cordic_sincos_chk #(
  .ANGLE_W (ANGLE_W),
  .DATA_W  (DATA_W),
  .STAGES  (STAGES)
) u_chk (.*);

// File: tb/cordic_sincos_bench.sv
`timescale 1ns/1ps
module cordic_sincos_bench;

  localparam int  LAT  = 16;
  localparam real AMP  = 32764.0;
  localparam real PI   = 3.14159265358979;
  localparam int  LOGN = 8192;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic               rstN    = 1'b0;
  logic               inValid = 1'b0;
  logic [15:0]        inAngle = '0;
  logic               outValid;
  logic signed [15:0] outSin, outCos;

  cordic_sincos u_cordic_sincos (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inAngle  (inAngle),
    .outValid (outValid),
    .outSin   (outSin),
    .outCos   (outCos)
  );

  int    total = 0;
  int    bad   = 0;
  bit    finished = 1'b0;
  int    cyc = 0;
  bit    vLog [LOGN];
  logic [15:0] aLog [LOGN];
  string tLog [LOGN];

  function automatic real fabs(input real v);
    return (v < 0.0) ? -v : v;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input real act, input real exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s cycle=%0d actual=%0f expected=%0f", tag, what, cyc, act, exp);
    end
  endtask

  // Compare outputs seen now with the sample driven LAT cycles ago.
  task automatic compare();
    bit  expV;
    real ang, es, ec, s, c;
    expV = (cyc >= LAT) ? vLog[cyc-LAT] : 1'b0;
    check(outValid == expV, "R2/R8", "outValid", real'(outValid), real'(expV));
    if (expV && outValid) begin
      ang = 2.0 * PI * real'(aLog[cyc-LAT]) / 65536.0;
      es  = AMP * $sin(ang);
      ec  = AMP * $cos(ang);
      s   = real'(outSin);
      c   = real'(outCos);
      check(fabs(s - es) <= 6.0, tLog[cyc-LAT], "sin", s, es);
      check(fabs(c - ec) <= 6.0, tLog[cyc-LAT], "cos", c, ec);
      if (fabs(es) > 1000.0) check((s > 0.0) == (es > 0.0), "R6", "sin sign", s, es);
      if (fabs(ec) > 1000.0) check((c > 0.0) == (ec > 0.0), "R6", "cos sign", c, ec);
      check(fabs($sqrt(s*s + c*c) - AMP) <= 8.0, "R7", "radius", $sqrt(s*s + c*c), AMP);
      check((outSin != -16'sd32768) && (outCos != -16'sd32768), "R7", "no -32768",
            (outSin < outCos) ? s : c, 0.0);
    end
  endtask

  task automatic step(input bit v, input logic [15:0] a, input string tag);
    @(negedge clk);
    compare();
    inValid   = v;
    inAngle   = a;
    vLog[cyc] = v;
    aLog[cyc] = a;
    tLog[cyc] = tag;
    cyc++;
  endtask

  initial begin
    logic [15:0] specials [9];
    string       spTags   [9];
    specials = '{16'h0000, 16'h0001, 16'h3FFF, 16'hFFFF, 16'h4000,
                 16'h8000, 16'hC000, 16'h2000, 16'h1555};
    spTags   = '{"R9", "R9", "R9", "R9", "R5", "R5", "R5", "R4", "R4"};

    // R1: idle under reset, even with a strobe offered
    repeat (3) @(negedge clk);
    inValid = 1'b1;
    inAngle = 16'h1234;
    repeat (3) begin
      @(negedge clk);
      check(outValid == 1'b0, "R1", "outValid in reset", real'(outValid), 0.0);
    end
    inValid = 1'b0;
    repeat (LAT + 2) @(negedge clk);
    check(outValid == 1'b0, "R1", "outValid in reset", real'(outValid), 0.0);
    rstN = 1'b1;
    @(negedge clk);
    check(outValid == 1'b0, "R1", "outValid after release", real'(outValid), 0.0);

    // Isolated boundary angles (R4, R5, R9)
    for (int k = 0; k < 9; k++) begin
      step(1'b1, specials[k], spTags[k]);
      for (int g = 0; g < 20; g++) step(1'b0, 16'h0000, "R8");
    end

    // Back-to-back sweep over the whole circle (R3)
    for (int k = 0; k < 1024; k++) step(1'b1, 16'(k * 64 + 5), "R3");

    // Random gaps with random ignored angles (R8)
    for (int k = 0; k < 1500; k++) step(($urandom % 3) != 0, 16'($urandom), "R8");

    // Drain
    for (int k = 0; k < LAT + 4; k++) step(1'b0, 16'hFFFF, "R8");

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #500000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog R2 actual=%0d expected=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule